// File: doc/BRIEF.md
# SMBus Register-Pointer Slave

This block is a bus slave for a two-wire SMBus/I2C bus that exposes a small file of 8-bit registers through a single persistent pointer. It runs entirely on the system clock. It oversamples the clock and data lines, finds start and stop conditions and clock edges, and pulls the data line low through an open-drain enable. It answers only to one fixed 7-bit device address.

A frame addressed for writing first delivers a pointer byte. Any further bytes in that same frame are stored into the register the pointer names. A frame addressed for reading sends back the register the pointer names, most significant bit first. The pointer keeps its value from one frame to the next. A master that wants a particular register therefore sets the pointer, issues a repeated start, and re-addresses the slave for a read.

If either bus line stays low longer than a programmable number of clock cycles, the slave drops whatever transfer it was in. It then waits for a fresh start condition.

Top module: `smbus_ptr_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal the device address (default 0101100b, so 58h for a write and 59h for a read). It acknowledges by holding SDA low during the ninth clock of that byte.
- R2: When the address byte does not match, the slave never pulls SDA low until the next start condition.
- R3: In a write-addressed frame, the first byte after the address is loaded into the register pointer and is acknowledged.
- R4: Each later byte in the same write frame is stored into the register the pointer selects and is acknowledged. The pointer does not advance, so a second byte overwrites the first.
- R5: A read-addressed frame returns the register the current pointer selects, whether the pointer was just set before a repeated start or was left by an earlier frame. The pointer persists across frames.
- R6: Read data leaves MSB first, beginning on the clock right after the address acknowledge. The slave changes its SDA drive only while SCL is low.
- R7: After the eighth read bit, a master NACK followed by a stop leaves SDA released and the slave idle.
- R8: A pointer value at or above the register count reads as 00h, and writes through it change no register.
- R9: If SCL or SDA stays low for the timeout count, the slave abandons the transfer and responds to nothing until a new start. A shorter low period does not disturb the transfer.
- R10: A start or repeated start seen at any point restarts address reception from the first bit.
- R11: After reset, SDA is released, the pointer is 0, and every register holds 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The embedded assertions check on every cycle that:
- SDA is released and the controller is idle one cycle after a stop or a timeout;
- a start always rearms address reception;
- the SDA drive changes only with SCL low;
- a mismatched address never leads to a drive;
- the pointer holds unless a pointer byte arrives;
- an out-of-range write leaves the register file untouched.

Only the bench scenarios can show the rest:
- that stored values come back intact and MSB first through the persistent pointer;
- that every one of the 254 foreign address bytes goes unanswered;
- that a low period just under the limit is tolerated while one over it aborts the frame.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXEND,
    ST_ACK,
    ST_TX,
    ST_MACKW,
    ST_MACKH
  } smbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic loadPtr;
    logic writeReg;
  } smbStrobe_t;

  // conditioned bus events
  typedef struct packed {
    logic sclLevel;
    logic sdaLevel;
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic busTimeout;
  } smbBusEv_t;

endpackage

// File: rtl/smb_bus_sense.sv
module smb_bus_sense
  import smb_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 1500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  output smbBusEv_t ev
);

  localparam int NUM_LINES = 2;
  localparam int CNT_W     = $clog2(TIMEOUT_CYCLES + 1);

  logic [NUM_LINES-1:0] lineRaw;
  logic [NUM_LINES-1:0] lineMeta;
  logic [NUM_LINES-1:0] lineSync;
  logic [NUM_LINES-1:0] linePrev;
  logic [NUM_LINES-1:0] lowHit;

  // index 0 = SCL, index 1 = SDA
  assign lineRaw = {sdaIn, sclIn};

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic [CNT_W-1:0] lowCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineMeta[g] <= 1'b1;
        lineSync[g] <= 1'b1;
        linePrev[g] <= 1'b1;
      end else begin
        lineMeta[g] <= lineRaw[g];
        lineSync[g] <= lineMeta[g];
        linePrev[g] <= lineSync[g];
      end
    end

    // per-line low-time counter, saturating at the limit
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lowCnt <= '0;
      end else if (lineSync[g]) begin
        lowCnt <= '0;
      end else if (lowCnt != CNT_W'(TIMEOUT_CYCLES)) begin
        lowCnt <= lowCnt + CNT_W'(1);
      end
    end

    assign lowHit[g] = !lineSync[g] && (lowCnt == CNT_W'(TIMEOUT_CYCLES - 1));
  end

  always_comb begin
    ev.sclLevel   = lineSync[0];
    ev.sdaLevel   = lineSync[1];
    ev.sclRise    = lineSync[0] && !linePrev[0];
    ev.sclFall    = !lineSync[0] && linePrev[0];
    ev.startSeen  = lineSync[0] && linePrev[0] && linePrev[1] && !lineSync[1];
    ev.stopSeen   = lineSync[0] && linePrev[0] && !linePrev[1] && lineSync[1];
    ev.busTimeout = |lowHit;
  end

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic       clk,
  input  logic       rstN,
  input  smbBusEv_t  ev,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output smbStrobe_t stb,
  output logic       sdaDriveLow
);

  localparam int BIT_W = 3;
  localparam logic [BIT_W-1:0] LAST_BIT = '1;

  smbState_t        state, nState;
  logic [BIT_W-1:0] bitCnt, nBit;
  logic             isAddr, nIsAddr;
  logic             rdMode, nRd;
  logic             ptrPending, nPend;

  always_comb begin
    nState  = state;
    nBit    = bitCnt;
    nIsAddr = isAddr;
    nRd     = rdMode;
    nPend   = ptrPending;
    stb     = '0;
    if (ev.busTimeout) begin
      nState = ST_IDLE;
    end else if (ev.startSeen) begin
      nState  = ST_RX;
      nBit    = '0;
      nIsAddr = 1'b1;
      nPend   = 1'b0;
    end else if (ev.stopSeen) begin
      nState = ST_IDLE;
    end else begin
      unique case (state)
        ST_RX: begin
          if (ev.sclRise) begin
            stb.shiftIn = 1'b1;
            if (bitCnt == LAST_BIT) nState = ST_RXEND;
            else                    nBit   = bitCnt + BIT_W'(1);
          end
        end
        ST_RXEND: begin
          if (ev.sclFall) begin
            if (isAddr) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                nState = ST_ACK;
                nRd    = rxByte[0];
                nPend  = !rxByte[0];
              end else begin
                nState = ST_IDLE;
              end
            end else begin
              nState = ST_ACK;
              if (ptrPending) begin
                stb.loadPtr = 1'b1;
                nPend       = 1'b0;
              end else begin
                stb.writeReg = 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            nBit    = '0;
            nIsAddr = 1'b0;
            if (isAddr && rdMode) begin
              stb.loadTx = 1'b1;
              nState     = ST_TX;
            end else begin
              nState = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (ev.sclFall) begin
            if (bitCnt == LAST_BIT) begin
              nState = ST_MACKW;
            end else begin
              stb.shiftTx = 1'b1;
              nBit        = bitCnt + BIT_W'(1);
            end
          end
        end
        ST_MACKW: begin
          if (ev.sclRise) nState = ev.sdaLevel ? ST_IDLE : ST_MACKH;
        end
        ST_MACKH: begin
          if (ev.sclFall) begin
            stb.loadTx = 1'b1;
            nBit       = '0;
            nState     = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      isAddr     <= 1'b0;
      rdMode     <= 1'b0;
      ptrPending <= 1'b0;
    end else begin
      state      <= nState;
      bitCnt     <= nBit;
      isAddr     <= nIsAddr;
      rdMode     <= nRd;
      ptrPending <= nPend;
    end
  end

  assign sdaDriveLow = (state == ST_ACK) || ((state == ST_TX) && !txBit);

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (ev.stopSeen && !ev.startSeen && !ev.busTimeout) |=> (state == ST_IDLE && !sdaDriveLow)); // R7
  AST_TIMEOUT_ABANDONS: assert property (@(posedge clk) disable iff (!rstN)
    ev.busTimeout |=> (state == ST_IDLE && !sdaDriveLow)); // R9
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rstN)
    (ev.startSeen && !ev.busTimeout) |=> (state == ST_RX && bitCnt == '0 && isAddr)); // R10
  AST_DRIVE_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaDriveLow) && !$past(ev.busTimeout || ev.startSeen || ev.stopSeen)) |-> !ev.sclLevel); // R6
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RXEND && isAddr && ev.sclFall && rxByte[7:1] != DEV_ADDR
     && !ev.startSeen && !ev.stopSeen && !ev.busTimeout) |=> !sdaDriveLow); // R2

endmodule

// File: rtl/smb_dpath.sv
module smb_dpath
  import smb_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  smbStrobe_t stb,
  input  logic       sdaBit,
  output logic [7:0] rxByte,
  output logic       txBit
);

  localparam int PTR_W  = 8;
  localparam int DATA_W = 8;

  logic [DATA_W-1:0]               shiftReg;
  logic [PTR_W-1:0]                ptr;
  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic [DATA_W-1:0]               rdByte;

  // selected register, 00h when the pointer is out of range
  always_comb begin
    rdByte = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == PTR_W'(i)) rdByte = regFile[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.loadTx) begin
      shiftReg <= rdByte;
    end else if (stb.shiftTx) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end else if (stb.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ptr <= '0;
    else if (stb.loadPtr) ptr <= shiftReg;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN)                                   regFile[g] <= '0;
      else if (stb.writeReg && ptr == PTR_W'(g))   regFile[g] <= shiftReg;
    end
  end

  assign rxByte = shiftReg;
  assign txBit  = shiftReg[DATA_W-1];

  AST_PTR_PERSISTS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadPtr |=> $stable(ptr)); // R5
  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeReg && ptr >= PTR_W'(NUM_REGS)) |=> $stable(regFile)); // R8

endmodule

// File: rtl/smbus_ptr_slave.sv
module smbus_ptr_slave
  import smb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR       = 7'h2C,
  parameter int          NUM_REGS       = 6,
  parameter int unsigned TIMEOUT_CYCLES = 1500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow
);

  smbBusEv_t  busEv;
  smbStrobe_t strobes;
  logic [7:0] rxByte;
  logic       txBit;

  smb_bus_sense #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_sense (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .ev    (busEv)
  );

  smb_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ev          (busEv),
    .rxByte      (rxByte),
    .txBit       (txBit),
    .stb         (strobes),
    .sdaDriveLow (sdaDriveLow)
  );

  smb_dpath #(.NUM_REGS(NUM_REGS)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (strobes),
    .sdaBit (busEv.sdaLevel),
    .rxByte (rxByte),
    .txBit  (txBit)
  );

endmodule

// File: tb/smbus_ptr_slave_bench.sv
module smbus_ptr_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int NREGS      = 6;
  localparam int TOUT       = 1000;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclLow = 1'b0;
  logic mSdaLow = 1'b0;
  logic sclLine, sdaLine, sdaDriveLow;

  assign sclLine = !mSclLow;
  assign sdaLine = !(mSdaLow || sdaDriveLow);

  always #(CLK_PERIOD / 2) clk = !clk;

  smbus_ptr_slave #(.DEV_ADDR(7'h2C), .NUM_REGS(NREGS), .TIMEOUT_CYCLES(TOUT)) u_smbus_ptr_slave (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclLine),
    .sdaIn       (sdaLine),
    .sdaDriveLow (sdaDriveLow)
  );

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;
  bit noDriveWin = 1'b0;
  int r2Viol = 0;
  int r6Viol = 0;
  logic prevScl = 1'b1;
  logic prevDrv = 1'b0;

  // R2 and R6 monitors
  always @(negedge clk) begin
    if (rstN) begin
      if (noDriveWin && sdaDriveLow) r2Viol++;
      if (sclLine && prevScl && (sdaDriveLow != prevDrv)) r6Viol++;
    end
    prevScl = sclLine;
    prevDrv = sdaDriveLow;
  end

  function automatic logic [7:0] valFor(input int p);
    return 8'((p * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic startC();
    mSdaLow = 1'b0; waitCyc(Q);
    mSclLow = 1'b0; waitCyc(Q);
    mSdaLow = 1'b1; waitCyc(Q);
    mSclLow = 1'b1; waitCyc(Q);
  endtask

  task automatic stopC();
    mSdaLow = 1'b1; waitCyc(Q);
    mSclLow = 1'b0; waitCyc(Q);
    mSdaLow = 1'b0; waitCyc(Q);
  endtask

  task automatic bitW(input logic b);
    mSdaLow = !b; waitCyc(Q);
    mSclLow = 1'b0; waitCyc(2 * Q);
    mSclLow = 1'b1; waitCyc(Q);
  endtask

  task automatic bitR(output logic b);
    mSdaLow = 1'b0; waitCyc(Q);
    mSclLow = 1'b0; waitCyc(Q);
    b = sdaLine; waitCyc(Q);
    mSclLow = 1'b1; waitCyc(Q);
  endtask

  task automatic byteW(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bitW(d[i]);
    bitR(b);
    acked = !b;
  endtask

  task automatic byteR(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bitR(b);
      d[i] = b;
    end
    bitW(nack);
  endtask

  task automatic wrFrame(input logic [7:0] p, input logic [7:0] d, input bit withData);
    logic a;
    startC();
    byteW(8'h58, a); chk("R1 write address ack", a, 1);
    byteW(p, a);     chk("R3 pointer byte ack", a, 1);
    if (withData) begin
      byteW(d, a);   chk("R4 data byte ack", a, 1);
    end
    stopC();
  endtask

  task automatic rdSet(input logic [7:0] p, output logic [7:0] d);
    logic a;
    startC();
    byteW(8'h58, a); chk("R1 write address ack", a, 1);
    byteW(p, a);     chk("R3 pointer byte ack", a, 1);
    startC();
    byteW(8'h59, a); chk("R1 read address ack", a, 1);
    byteR(d, 1'b1);
    chk("R7 released after NACK", int'(sdaDriveLow), 0);
    stopC();
  endtask

  task automatic rdDirect(output logic [7:0] d);
    logic a;
    startC();
    byteW(8'h59, a); chk("R1 read address ack", a, 1);
    byteR(d, 1'b1);
    stopC();
    chk("R7 released after stop", int'(sdaDriveLow), 0);
  endtask

  initial begin
    logic [7:0] d;
    logic a;
    waitCyc(5);
    chk("R11 reset drive", int'(sdaDriveLow), 0);
    rstN = 1'b1;
    waitCyc(5);
    chk("R11 idle drive", int'(sdaDriveLow), 0);
    rdDirect(d);
    chk("R11 reg0 after reset", d, 0);
    rdSet(8'd5, d);
    chk("R11 reg5 after reset", d, 0);

    // R4/R8: write every pointer value 0..7
    for (int p = 0; p < 8; p++) wrFrame(8'(p), valFor(p), 1'b1);
    // R5/R8: read them back through pointer + repeated start
    for (int p = 0; p < 8; p++) begin
      rdSet(8'(p), d);
      if (p < NREGS) chk("R5 readback", d, valFor(p));
      else           chk("R8 out-of-range reads zero", d, 0);
    end
    rdDirect(d);
    chk("R8 persisted out-of-range pointer", d, 0);

    // R5: pointer-only frame, then direct reads
    wrFrame(8'd2, 8'h00, 1'b0);
    rdDirect(d); chk("R5 direct read 1", d, valFor(2));
    rdDirect(d); chk("R5 direct read 2", d, valFor(2));

    // R4: two data bytes, no auto-increment
    startC();
    byteW(8'h58, a); chk("R1 ack", a, 1);
    byteW(8'd1, a);  chk("R3 ack", a, 1);
    byteW(8'hA5, a); chk("R4 first data ack", a, 1);
    byteW(8'h3C, a); chk("R4 second data ack", a, 1);
    stopC();
    rdSet(8'd1, d); chk("R4 last byte wins", d, 8'h3C);
    rdSet(8'd2, d); chk("R4 neighbour untouched", d, valFor(2));

    // R9: low period under the limit is tolerated
    startC();
    byteW(8'h58, a); chk("R1 ack", a, 1);
    bitW(0); bitW(0); bitW(0); bitW(0);
    waitCyc(TOUT - 200);
    bitW(0); bitW(0); bitW(1); bitW(1);
    bitR(a); chk("R9 short low still acked", int'(!a), 1);
    stopC();
    rdDirect(d); chk("R9 pointer set after short low", d, valFor(3));

    // R9: SCL held low too long aborts the pointer byte
    startC();
    byteW(8'h58, a); chk("R1 ack", a, 1);
    bitW(0); bitW(0); bitW(0); bitW(0);
    waitCyc(TOUT + 100);
    bitW(0); bitW(0); bitW(0); bitW(0);
    bitR(a); chk("R9 no ack after SCL timeout", int'(!a), 0);
    mSdaLow = 1'b0; waitCyc(Q);
    mSclLow = 1'b0; waitCyc(Q);
    rdDirect(d); chk("R9 pointer kept after abort", d, valFor(3));

    // R9: SDA held low with SCL high
    startC();
    mSclLow = 1'b0; waitCyc(TOUT + 100);
    mSclLow = 1'b1; waitCyc(Q);
    byteW(8'h58, a); chk("R9 no ack after SDA timeout", a, 0);
    stopC();

    // R10: repeated start in the middle of a byte
    startC();
    byteW(8'h58, a); chk("R1 ack", a, 1);
    bitW(1); bitW(0); bitW(1);
    startC();
    byteW(8'h59, a); chk("R10 address after mid-byte restart", a, 1);
    byteR(d, 1'b1);  chk("R10 read after restart", d, valFor(3));
    stopC();

    // R2: every foreign address byte is ignored
    for (int b = 0; b < 256; b++) begin
      if (b != 8'h58 && b != 8'h59) begin
        startC();
        noDriveWin = 1'b1;
        byteW(8'(b), a);
        noDriveWin = 1'b0;
        chk("R2 foreign address not acked", a, 0);
        stopC();
      end
    end
    chk("R2 no drive in foreign frames", r2Viol, 0);
    rdDirect(d); chk("R2 pointer unaffected", d, valFor(3));
    chk("R6 drive changes only with SCL low", r6Viol, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog (all requirements): actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule